// File: doc/BRIEF.md
# Reservation Monitor for Atomic Update Sequences

This block holds one memory reservation for load-linked / store-conditional style atomic sequences. A reserving load records the word address it touched and marks the reservation live with a recorded size of four bytes. A later conditional store compares its own address against that record. The store may go ahead only if the reservation is still live, still four bytes long and the addresses agree exactly. The block reports the outcome in a four-bit condition code and drops the reservation whatever the outcome.

An external invalidate, raised by whatever coherence logic watches other writers, kills the reservation. A new reserving load replaces any earlier one. The conditional store's result appears one clock after its request as a single-cycle pulse. That pulse carries the memory write enable and the condition code. The live flag and saved address are visible at all times.

Top module: `rsv_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsv_valid` is 0, `rsv_addr` is 0, and `sc_done`, `sc_wr_en` and `sc_status` are 0.
- R2: A cycle with `lr_req` high makes `rsv_valid` 1 and `rsv_addr` equal to that cycle's `eff_addr` from the next cycle on.
- R3: A conditional store made while the reservation is live with matching address succeeds: one cycle later `sc_wr_en` is 1 and `sc_status` bit 1 is 1.
- R4: A conditional store whose address differs in any bit from the saved address fails: `sc_wr_en` is 0 and `sc_status` bit 1 is 0.
- R5: A conditional store made with no live reservation fails, whatever its address.
- R6: `sc_status` is 4'b0010 on success and 4'b0000 on failure, with bit 0 set to the `so_flag` value sampled with the request; bits 3 and 2 are always 0.
- R7: Every conditional store, whether it succeeds or fails, leaves `rsv_valid` at 0, so an immediately repeated store to the same address fails.
- R8: `inval` high without `lr_req` leaves `rsv_valid` at 0 in the next cycle.
- R9: A second reserving load replaces the saved address; a store to the first address then fails and one to the second address succeeds.
- R10: When `lr_req` and `inval` are high in the same cycle, the reservation is set from `lr_req`.
- R11: When `lr_req` and `sc_req` are high in the same cycle, the store is judged against the reservation held before that cycle, and the new reservation stays live afterwards.
- R12: `sc_done` is high exactly in the cycle after each `sc_req` cycle; when `sc_done` is 0, `sc_wr_en` and `sc_status` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_req | input | 1 | Reserving load strobe |
| sc_req | input | 1 | Conditional store strobe |
| eff_addr | input | 32 | Effective address of the current load or store |
| so_flag | input | 1 | Summary overflow flag, copied into status bit 0 |
| inval | input | 1 | External reservation kill |
| sc_done | output | 1 | Conditional store result valid pulse |
| sc_wr_en | output | 1 | Memory write permitted for the conditional store |
| sc_status | output | 4 | Condition code of the conditional store |
| rsv_valid | output | 1 | Reservation is live |
| rsv_addr | output | 32 | Saved reservation address |

## Verification
The checker watches these on every cycle: the one-cycle result pulse and its quiet outputs when idle, the match between write enable and the success bit, the copied overflow bit, capture of the address on a reserving load, and the loss of the reservation after a store or an invalidate. It also checks that a store with no live reservation never writes. The bench scenarios show the behaviours that depend on history. These are replacement of one reservation by a later load, repeated stores after a success, and single-bit address mismatches. They also include the two same-cycle collisions, where the outcome can only be seen as the result of a whole sequence.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  localparam int unsigned STAT_W = 4;

  // condition code: bit1 = store performed, bit0 = overflow summary copy
  function automatic logic [STAT_W-1:0] status_code(input logic hit, input logic so);
    logic [STAT_W-1:0] s;
    s    = '0;
    s[1] = hit;
    s[0] = so;
    return s;
  endfunction

  function automatic logic addr_hit(input logic live, input logic len_ok,
                                    input logic [31:0] saved, input logic [31:0] cur);
    return live && len_ok && (saved == cur);
  endfunction

endpackage

// File: rtl/rsv_store.sv
module rsv_store #(
  parameter int unsigned AW    = 32,
  parameter int unsigned LW    = 4,
  parameter int unsigned BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [AW-1:0] addr_i,
  output logic          live_o,
  output logic [LW-1:0] len_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [LW-1:0] LEN_VAL = LW'(BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_o <= 1'b0;
      len_o  <= '0;
      addr_o <= '0;
    end else if (set_i) begin
      live_o <= 1'b1;
      len_o  <= LEN_VAL;
      addr_o <= addr_i;
    end else if (clr_i) begin
      live_o <= 1'b0;
      len_o  <= '0;
    end
  end
endmodule

// File: rtl/rsv_check.sv
module rsv_check #(
  parameter int unsigned AW    = 32,
  parameter int unsigned LW    = 4,
  parameter int unsigned BYTES = 4
) (
  input  logic          live_i,
  input  logic [LW-1:0] len_i,
  input  logic [AW-1:0] saved_i,
  input  logic [AW-1:0] cur_i,
  output logic          hit_o
);
  localparam logic [LW-1:0] LEN_VAL = LW'(BYTES);
  logic [31:0] saved_w;
  logic [31:0] cur_w;

  always_comb begin
    saved_w = 32'(saved_i);
    cur_w   = 32'(cur_i);
    hit_o   = rsv_pkg::addr_hit(live_i, len_i == LEN_VAL, saved_w, cur_w);
  end
endmodule

// File: rtl/rsv_result.sv
module rsv_result #(
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic          hit_i,
  input  logic          so_i,
  output logic          done_o,
  output logic          wr_o,
  output logic [SW-1:0] stat_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      wr_o   <= 1'b0;
      stat_o <= '0;
    end else begin
      done_o <= fire_i;
      wr_o   <= fire_i && hit_i;
      stat_o <= fire_i ? SW'(rsv_pkg::status_code(hit_i, so_i)) : '0;
    end
  end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
  parameter int unsigned AW    = 32,
  parameter int unsigned LW    = 4,
  parameter int unsigned BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lr_req,
  input  logic                      sc_req,
  input  logic [AW-1:0]             eff_addr,
  input  logic                      so_flag,
  input  logic                      inval,
  output logic                      sc_done,
  output logic                      sc_wr_en,
  output logic [rsv_pkg::STAT_W-1:0] sc_status,
  output logic                      rsv_valid,
  output logic [AW-1:0]             rsv_addr
);
  // named internal events
  logic          lr_take;
  logic          sc_take;
  logic          clr_evt;
  logic          hit_now;
  logic [LW-1:0] rsv_len;

  assign lr_take = lr_req;
  assign sc_take = sc_req;
  assign clr_evt = sc_req || inval;

  rsv_store #(.AW(AW), .LW(LW), .BYTES(BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .set_i(lr_take), .clr_i(clr_evt),
    .addr_i(eff_addr), .live_o(rsv_valid), .len_o(rsv_len), .addr_o(rsv_addr)
  );

  rsv_check #(.AW(AW), .LW(LW), .BYTES(BYTES)) u_check (
    .live_i(rsv_valid), .len_i(rsv_len), .saved_i(rsv_addr),
    .cur_i(eff_addr), .hit_o(hit_now)
  );

  rsv_result #(.SW(rsv_pkg::STAT_W)) u_result (
    .clk(clk), .rst_n(rst_n), .fire_i(sc_take), .hit_i(hit_now),
    .so_i(so_flag), .done_o(sc_done), .wr_o(sc_wr_en), .stat_o(sc_status)
  );
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lr_req,
  input logic          sc_req,
  input logic [AW-1:0] eff_addr,
  input logic          so_flag,
  input logic          inval,
  input logic          sc_done,
  input logic          sc_wr_en,
  input logic [3:0]    sc_status,
  input logic          rsv_valid,
  input logic [AW-1:0] rsv_addr
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (sc_done == $past(sc_req)));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_done |-> (!sc_wr_en && sc_status == 4'h0));
  // R3
  wr_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> (sc_wr_en == sc_status[1] && sc_status[3:2] == 2'b00));
  // R6
  so_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sc_done) |-> (sc_status[0] == $past(so_flag)));
  // R2
  lr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(lr_req)) |-> (rsv_valid && rsv_addr == $past(eff_addr)));
  // R7
  sc_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(sc_req && !lr_req)) |-> !rsv_valid);
  // R8
  inval_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(inval && !lr_req)) |-> !rsv_valid);
  // R5
  no_rsv_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sc_done && !$past(rsv_valid)) |-> !sc_wr_en);
endmodule

bind rsv_monitor rsv_monitor_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lr_req(lr_req), .sc_req(sc_req),
  .eff_addr(eff_addr), .so_flag(so_flag), .inval(inval),
  .sc_done(sc_done), .sc_wr_en(sc_wr_en), .sc_status(sc_status),
  .rsv_valid(rsv_valid), .rsv_addr(rsv_addr)
);

// File: tb/sim_rsv_monitor.sv
`timescale 1ns/1ps
module sim_rsv_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lr_req = 1'b0, sc_req = 1'b0, so_flag = 1'b0, inval = 1'b0;
  logic [31:0] eff_addr = '0;
  logic        sc_done, sc_wr_en, rsv_valid;
  logic [3:0]  sc_status;
  logic [31:0] rsv_addr;

  always #4 clk = ~clk; // 125 MHz

  rsv_monitor u0 (
    .clk(clk), .rst_n(rst_n), .lr_req(lr_req), .sc_req(sc_req),
    .eff_addr(eff_addr), .so_flag(so_flag), .inval(inval),
    .sc_done(sc_done), .sc_wr_en(sc_wr_en), .sc_status(sc_status),
    .rsv_valid(rsv_valid), .rsv_addr(rsv_addr)
  );

  int checks = 0;
  int fails  = 0;
  logic [4:0] expq[$];
  string      tagq[$];

  // bench model of the reservation
  logic        m_live = 1'b0;
  logic [31:0] m_addr = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one operation: drive one cycle, then idle one cycle
  task automatic step(input bit lr, input bit sc, input logic [31:0] a,
                      input bit so, input bit inv, input string tag);
    bit ok_hit;
    @(negedge clk);
    lr_req = lr; sc_req = sc; eff_addr = a; so_flag = so; inval = inv;
    if (sc) begin
      ok_hit = m_live && (m_addr == a);
      expq.push_back({ok_hit, 2'b00, ok_hit, so});
      tagq.push_back(tag);
    end
    if (lr) begin m_live = 1'b1; m_addr = a; end
    else if (sc || inv) m_live = 1'b0;
    @(negedge clk);
    lr_req = 0; sc_req = 0; so_flag = 0; inval = 0;
  endtask

  task automatic chk_state(input string tag);
    chk(rsv_valid == m_live, {tag, " valid"}, 64'(rsv_valid), 64'(m_live));
    if (m_live) chk(rsv_addr == m_addr, {tag, " addr"}, 64'(rsv_addr), 64'(m_addr));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (sc_done) begin
        if (expq.size() == 0) chk(0, "R12 unexpected sc_done", 1, 0);
        else begin
          logic [4:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk({sc_wr_en, sc_status} == e, t, 64'({sc_wr_en, sc_status}), 64'(e));
        end
      end else if (sc_wr_en || sc_status != 0) begin
        chk(0, "R12 idle outputs", 64'({sc_wr_en, sc_status}), 0);
      end
    end
  end

  bit finished = 0;
  initial begin
    #200000;
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!rsv_valid && rsv_addr == 0, "R1 reset state", 64'({rsv_valid, rsv_addr}), 0);
    chk(!sc_done && !sc_wr_en && sc_status == 0, "R1 reset outputs", 64'({sc_done, sc_wr_en, sc_status}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsv_valid && rsv_addr == 0, "R1 after reset", 64'({rsv_valid, rsv_addr}), 0);

    // R5 store without reservation
    step(0, 1, 32'h0000_0000, 0, 0, "R5 no reservation");
    step(0, 1, 32'h0000_1000, 1, 0, "R5 R6 no reservation so=1");
    chk_state("R5");
    // R2 reserve, R3 success
    step(1, 0, 32'h0000_1000, 0, 0, "R2");
    chk_state("R2 capture");
    step(0, 1, 32'h0000_1000, 0, 0, "R3 success");
    chk_state("R7 after success");
    // R7 repeated store fails
    step(0, 1, 32'h0000_1000, 0, 0, "R7 repeat store");
    // R6 success with so=1 -> 0x3
    step(1, 0, 32'hDEAD_BEE0, 0, 0, "R6 setup");
    step(0, 1, 32'hDEAD_BEE0, 1, 0, "R6 success so=1");
    // R4 single-bit mismatches, low and high bit
    step(1, 0, 32'h8000_0040, 0, 0, "R4 setup");
    step(0, 1, 32'h8000_0041, 0, 0, "R4 low bit mismatch");
    chk_state("R7 after failure");
    step(1, 0, 32'h8000_0040, 0, 0, "R4 setup2");
    step(0, 1, 32'h0000_0040, 1, 0, "R4 R6 high bit mismatch so=1");
    // R8 invalidate
    step(1, 0, 32'h0000_2000, 0, 0, "R8 setup");
    step(0, 0, 32'h0000_0000, 0, 1, "R8 inval");
    chk_state("R8 after inval");
    step(0, 1, 32'h0000_2000, 0, 0, "R8 store after inval");
    // R9 replace
    step(1, 0, 32'h0000_3000, 0, 0, "R9 first");
    step(1, 0, 32'h0000_4000, 0, 0, "R9 second");
    chk_state("R9 replaced");
    step(0, 1, 32'h0000_3000, 0, 0, "R9 old address");
    step(1, 0, 32'h0000_3000, 0, 0, "R9 first again");
    step(1, 0, 32'h0000_4000, 0, 0, "R9 second again");
    step(0, 1, 32'h0000_4000, 0, 0, "R9 new address");
    // R10 lr + inval
    step(1, 0, 32'h0000_5000, 0, 1, "R10 lr with inval");
    chk_state("R10 state");
    step(0, 1, 32'h0000_5000, 0, 0, "R10 store succeeds");
    // R11 lr + sc same cycle
    step(1, 0, 32'h0000_6000, 0, 0, "R11 setup");
    step(1, 1, 32'h0000_6000, 0, 0, "R11 combined vs old");
    chk_state("R11 new reservation kept");
    step(0, 1, 32'h0000_6000, 0, 0, "R11 follow-up");
    step(1, 1, 32'h0000_7000, 0, 0, "R11 combined no prior");
    chk_state("R11 state2");
    // R12 back-to-back stores: pulse per request
    step(0, 1, 32'h0000_7000, 1, 0, "R12 pulse a");
    step(0, 1, 32'h0000_7000, 0, 0, "R12 pulse b");
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R12 all results seen", 64'(expq.size()), 0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule